// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects interrupt events for a small microcontroller core and turns them into a vectored call. There are five sources. Two are external pins, each passed through a synchroniser and an edge detector that software sets to rising, falling or both edges. The other three are one-cycle pulses from a timer/event counter, a time-base divider and a real-time clock. Each source has an enable bit and a request flag. These bits, together with a global master enable, are packed into two 8-bit control registers that software writes through a simple write port and reads back through two output buses.

A request is taken when its flag and enable are set, the master enable is on, and the core reports that its return stack is not full. On the cycle it is taken, the controller drops the serviced flag and the master enable. It then presents a single-cycle call pulse together with the vector address. Nesting only happens if the service routine turns the master enable back on. Only the program counter is saved by the core; status is not part of the call. A wake-up output tells a halted core that some enabled request is pending, whatever the master enable and stack state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both control registers read 0x00, `call_req` is 0 and `wake` is 0.
- R2: Each external pin has a 2-bit mode field in `ext_mode` (pin p uses bits 2p+1:2p). Bit 0 of the field arms rising edges and bit 1 arms falling edges, so 00 ignores the pin and 11 takes both edges. An armed edge sets that pin's flag on the third rising clock edge after the pin changes.
- R3: Control register 0 holds master enable in bit 0, the enables for sources 0..2 in bits 1..3 and their flags in bits 4..6; bit 7 reads 0. Control register 1 holds the enables for sources 3..4 in bits 0..1 and their flags in bits 4..5; the other bits read 0. `wr_sel`=0 writes register 0 and `wr_sel`=1 writes register 1. Written flag values, including 1, are stored.
- R4: Sources 0 and 1 are external pins 0 and 1; sources 2, 3 and 4 are `int_pulse` bits 0, 1 and 2. A pulse sets its flag at the next clock edge.
- R5: A request is taken when flag, enable and master enable are all set and `stack_full` is 0. `call_req` goes high for exactly one cycle, one clock after the taking condition is present.
- R6: The vector for source s is 0x04 + 4·s (0x04, 0x08, 0x0C, 0x10, 0x14). It is valid while `call_req` is high.
- R7: When several enabled requests are pending, the lowest-numbered source is taken first.
- R8: On taking a request, its flag and the master enable are cleared in the same edge that raises `call_req`. The other pending flags stay set.
- R9: With the master enable clear, flags still get set and no call is made. A source with its enable clear never causes a call, even though its flag is set.
- R10: While `stack_full` is 1, no call is made and the pending flag is kept. The call follows one clock after `stack_full` falls.
- R11: `wake` is 1 whenever any source has both flag and enable set, independent of the master enable and `stack_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | Asynchronous external interrupt pins |
| ext_mode | input | 4 | Edge mode per pin: bit0 rising, bit1 falling |
| int_pulse | input | 3 | Internal event pulses: timer, time base, real-time clock |
| wr_en | input | 1 | Control register write strobe |
| wr_sel | input | 1 | Register select: 0 = register 0, 1 = register 1 |
| wr_data | input | 8 | Write data |
| stack_full | input | 1 | Core return stack is full |
| ctl0_q | output | 8 | Readback of control register 0 |
| ctl1_q | output | 8 | Readback of control register 1 |
| call_req | output | 1 | One-cycle call request to the core |
| call_vec | output | 8 | Vector address of the call |
| wake | output | 1 | Wake-up request for halt mode |

## Verification
Each result has a fixed latency, and the bench samples on the falling clock edge exactly where that result is due.

- A pin change reaches its flag on the third rising edge, so the bench checks that the flag is still clear two edges after the change and set after the third.
- An internal pulse shows in the flag after one edge, and the call follows one edge later.
- A register write that completes a taking condition gives `call_req` and the cleared flag and master bits one edge after the write.

The priority sweep walks through all 31 non-empty pending patterns, re-arming the master enable after every call. The expected vector and readback come from the lowest set bit of the remaining pattern.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int CTL_W    = 8;
   localparam int R0_SRCS  = 3;
   localparam int R1_SRCS  = 4;
   localparam int FLAG_OFS = 4;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

   // which control register holds source i
   function automatic int src_reg(input int i);
      return (i < R0_SRCS) ? 0 : 1;
   endfunction

   // bit position of the enable of source i inside its register
   function automatic int src_en_bit(input int i);
      return (i < R0_SRCS) ? i + 1 : i - R0_SRCS;
   endfunction

   // bit position of the flag of source i inside its register
   function automatic int src_fl_bit(input int i);
      return (i < R0_SRCS) ? i + FLAG_OFS : i - R0_SRCS + FLAG_OFS;
   endfunction

endpackage

// File: rtl/irqc_edge_detect.sv
module irqc_edge_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] mode,
   output logic       hit
);
   import irqc_pkg::*;

   initial begin
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4)
         $error("irqc_edge_detect: SYNC_STAGES out of range");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [SYNC_STAGES:0]   fill_q;
   logic                   prev_q;
   logic                   level;
   logic                   armed;
   logic                   rise;
   logic                   fall;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= pin;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         end
      end
   endgenerate

   assign level = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         fill_q <= '0;
      end else begin
         prev_q <= level;
         fill_q <= {fill_q[SYNC_STAGES-1:0], 1'b1};
      end
   end

   assign armed = fill_q[SYNC_STAGES];
   assign rise  = level & ~prev_q;
   assign fall  = ~level & prev_q;
   assign hit   = armed & ((rise & mode[0]) | (fall & mode[1]));

endmodule

// File: rtl/irqc_req_bank.sv
module irqc_req_bank #(
   parameter int N_SRC = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [7:0]       wr_data,
   input  logic [N_SRC-1:0] set_vec,
   input  logic [N_SRC-1:0] take_vec,
   input  logic             take,
   output logic [N_SRC-1:0] en_vec,
   output logic [N_SRC-1:0] fl_vec,
   output logic             master,
   output logic [7:0]       ctl0,
   output logic [7:0]       ctl1
);
   import irqc_pkg::*;

   initial begin
      if (N_SRC < 2 || N_SRC > R0_SRCS + R1_SRCS)
         $error("irqc_req_bank: N_SRC out of range");
   end

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         localparam int RSEL = src_reg(i);
         localparam int EB   = src_en_bit(i);
         localparam int FB   = src_fl_bit(i);

         logic en_r, fl_r, en_d, fl_d, wr_hit;

         assign wr_hit = wr_en && (wr_sel == 1'(RSEL));

         always_comb begin
            en_d = en_r;
            fl_d = fl_r;
            if (wr_hit) begin
               en_d = wr_data[EB];
               fl_d = wr_data[FB];
            end
            if (take_vec[i]) fl_d = 1'b0;
            if (set_vec[i])  fl_d = 1'b1;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_r <= 1'b0;
               fl_r <= 1'b0;
            end else begin
               en_r <= en_d;
               fl_r <= fl_d;
            end
         end

         assign en_vec[i] = en_r;
         assign fl_vec[i] = fl_r;

         // R8
         taken_flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (take_vec[i] && !set_vec[i]) |=> !fl_r);
      end
   endgenerate

   logic master_d;

   always_comb begin
      master_d = master;
      if (wr_en && !wr_sel) master_d = wr_data[0];
      if (take)             master_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) master <= 1'b0;
      else        master <= master_d;
   end

   // R8
   master_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !master);

   logic [1:0][7:0] rb;

   always_comb begin
      rb       = '0;
      rb[0][0] = master;
      for (int i = 0; i < N_SRC; i++) begin
         rb[src_reg(i)][src_en_bit(i)] = en_vec[i];
         rb[src_reg(i)][src_fl_bit(i)] = fl_vec[i];
      end
   end

   assign ctl0 = rb[0];
   assign ctl1 = rb[1];

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
   parameter int N_SRC    = 5,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 4,
   parameter int VEC_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req,
   input  logic             master,
   input  logic             stack_full,
   output logic [N_SRC-1:0] grant,
   output logic             take,
   output logic             call_req,
   output logic [VEC_W-1:0] call_vec
);
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
   localparam int VEC_TOP = VEC_BASE + (N_SRC - 1) * VEC_STEP;

   initial begin
      if (VEC_TOP >= (1 << VEC_W))
         $error("irqc_arbiter: vector table does not fit VEC_W");
      if (VEC_STEP < 1)
         $error("irqc_arbiter: VEC_STEP must be positive");
   end

   logic [IDX_W-1:0] idx;

   // lowest index wins: scan from the top so the last hit is the lowest
   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IDX_W'(i);
         end
      end
   end

   assign take = master && !stack_full && (|req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         call_req <= 1'b0;
         call_vec <= '0;
      end else begin
         call_req <= take;
         if (take) call_vec <= VEC_W'(VEC_BASE + int'(idx) * VEC_STEP);
      end
   end

   // R7
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R10
   call_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> $past(!stack_full && master));

   // R5
   call_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |=> !call_req);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int N_EXT       = 2,
   parameter int N_INT       = 3,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = 8,
   parameter int VEC_BASE    = 4,
   parameter int VEC_STEP    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_EXT-1:0]   ext_pin,
   input  logic [2*N_EXT-1:0] ext_mode,
   input  logic [N_INT-1:0]   int_pulse,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [7:0]         wr_data,
   input  logic               stack_full,
   output logic [7:0]         ctl0_q,
   output logic [7:0]         ctl1_q,
   output logic               call_req,
   output logic [VEC_W-1:0]   call_vec,
   output logic               wake
);
   import irqc_pkg::*;

   localparam int N_SRC = N_EXT + N_INT;

   initial begin
      if (N_EXT < 1 || N_INT < 1)
         $error("irq_vector_ctrl: need at least one source of each kind");
      if (N_SRC > R0_SRCS + R1_SRCS)
         $error("irq_vector_ctrl: too many sources for two control registers");
   end

   logic [N_SRC-1:0] set_vec;
   logic [N_SRC-1:0] en_vec;
   logic [N_SRC-1:0] fl_vec;
   logic [N_SRC-1:0] req;
   logic [N_SRC-1:0] grant;
   logic             master;
   logic             take;

   generate
      for (genvar p = 0; p < N_EXT; p++) begin : g_ext
         irqc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (ext_pin[p]),
            .mode (ext_mode[2*p +: 2]),
            .hit  (set_vec[p])
         );
      end
   endgenerate

   assign set_vec[N_SRC-1:N_EXT] = int_pulse;

   irqc_req_bank #(.N_SRC(N_SRC)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .set_vec (set_vec),
      .take_vec(take ? grant : '0),
      .take    (take),
      .en_vec  (en_vec),
      .fl_vec  (fl_vec),
      .master  (master),
      .ctl0    (ctl0_q),
      .ctl1    (ctl1_q)
   );

   assign req  = fl_vec & en_vec;
   assign wake = |req;

   irqc_arbiter #(
      .N_SRC   (N_SRC),
      .VEC_W   (VEC_W),
      .VEC_BASE(VEC_BASE),
      .VEC_STEP(VEC_STEP)
   ) i_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .master    (master),
      .stack_full(stack_full),
      .grant     (grant),
      .take      (take),
      .call_req  (call_req),
      .call_vec  (call_vec)
   );

   // R9
   no_call_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      call_req |-> $past(|(fl_vec & en_vec)));

endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] ext_pin;
   logic [3:0] ext_mode;
   logic [2:0] int_pulse;
   logic       wr_en;
   logic       wr_sel;
   logic [7:0] wr_data;
   logic       stack_full;
   logic [7:0] ctl0_q;
   logic [7:0] ctl1_q;
   logic       call_req;
   logic [7:0] call_vec;
   logic       wake;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   irq_vector_ctrl i_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_mode(ext_mode),
      .int_pulse(int_pulse), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .stack_full(stack_full), .ctl0_q(ctl0_q), .ctl1_q(ctl1_q),
      .call_req(call_req), .call_vec(call_vec), .wake(wake)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] ex0(input logic [4:0] en, input logic [4:0] fl, input logic m);
      return {1'b0, fl[2:0], en[2:0], m};
   endfunction

   function automatic logic [7:0] ex1(input logic [4:0] en, input logic [4:0] fl);
      return {2'b00, fl[4:3], 2'b00, en[4:3]};
   endfunction

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_src(input logic [4:0] en, input logic [4:0] fl, input logic m);
      wr(1'b1, ex1(en, fl));
      wr(1'b0, ex0(en, fl, m));
   endtask

   initial begin
      rst_n = 1'b0; ext_pin = '0; ext_mode = '0; int_pulse = '0;
      wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; stack_full = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);

      // R1 reset state
      check("R1 ctl0", ctl0_q, 0);
      check("R1 ctl1", ctl1_q, 0);
      check("R1 call_req", call_req, 0);
      check("R1 wake", wake, 0);

      // R3 register layout and readback, R11 wake without master
      wr(1'b0, 8'hFE);
      check("R3 ctl0 readback", ctl0_q, 8'h7E);
      check("R11 wake with master off", wake, 1);
      check("R9 no call with master off", call_req, 0);
      wr(1'b1, 8'hFF);
      check("R3 ctl1 readback", ctl1_q, 8'h33);
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h00);
      check("R3 cleared ctl0", ctl0_q, 0);
      check("R3 cleared ctl1", ctl1_q, 0);

      // R2 edge mode sweep over both pins, all modes, both directions
      for (int p = 0; p < 2; p++) begin
         for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
               logic lvl;
               logic exp_fl;
               wr(1'b0, 8'h00);
               @(negedge clk);
               ext_mode[2*p +: 2] = 2'(m);
               ext_pin[p] = ~ext_pin[p];
               lvl = ext_pin[p];
               exp_fl = lvl ? 1'(m & 1) : 1'((m >> 1) & 1);
               repeat (2) @(negedge clk);
               check("R2 flag not yet set", ctl0_q[4+p], 0);
               @(negedge clk);
               check($sformatf("R2 pin%0d mode%0d level%0d", p, m, lvl), ctl0_q[4+p], exp_fl);
               repeat (2) @(negedge clk);
            end
         end
      end
      ext_mode = '0;
      wr(1'b0, 8'h00);

      // R5 R6 external pin 0 rising edge to call
      wr(1'b0, 8'h03);
      ext_mode = 4'b0001;
      @(negedge clk);
      ext_pin[0] = 1'b1;
      repeat (3) @(negedge clk);
      check("R5 no call before due", call_req, 0);
      check("R11 wake pending", wake, 1);
      @(negedge clk);
      check("R5 call on ext0", call_req, 1);
      check("R6 vector ext0", call_vec, 8'h04);
      check("R8 flag and master cleared", ctl0_q, 8'h02);
      @(negedge clk);
      check("R5 call is one cycle", call_req, 0);
      ext_pin[0] = 1'b0;
      ext_mode = '0;
      repeat (4) @(negedge clk);

      // R4 R6 internal sources
      for (int s = 2; s < 5; s++) begin
         logic [4:0] en;
         en = 5'(1 << s);
         set_src(en, 5'h00, 1'b1);
         @(negedge clk);
         int_pulse[s-2] = 1'b1;
         @(negedge clk);
         int_pulse = '0;
         check("R4 flag after pulse", {ctl1_q, ctl0_q}, {ex1(en, en), ex0(en, en, 1'b1)});
         check("R4 call not yet", call_req, 0);
         @(negedge clk);
         check($sformatf("R5 call src%0d", s), call_req, 1);
         check($sformatf("R6 vector src%0d", s), call_vec, 4 + 4 * s);
         check("R8 readback after take", {ctl1_q, ctl0_q}, {ex1(en, 5'h00), ex0(en, 5'h00, 1'b0)});
         @(negedge clk);
         check("R5 one-cycle call", call_req, 0);
      end

      // R7 R8 priority sweep over all pending patterns
      for (int pat = 1; pat < 32; pat++) begin
         logic [4:0] rem;
         rem = 5'(pat);
         set_src(5'h1F, rem, 1'b0);
         check("R9 no call with master off", call_req, 0);
         for (int k = 0; k < 5; k++) begin
            if (rem != 5'h00) begin
               int low;
               low = 0;
               for (int b = 4; b >= 0; b--) if (rem[b]) low = b;
               set_src(5'h1F, rem, 1'b1);
               @(negedge clk);
               rem[low] = 1'b0;
               check($sformatf("R7 call pattern %0h", pat), call_req, 1);
               check($sformatf("R7 vector pattern %0h", pat), call_vec, 4 + 4 * low);
               check("R8 others stay pending", {ctl1_q, ctl0_q},
                     {ex1(5'h1F, rem), ex0(5'h1F, rem, 1'b0)});
            end
         end
      end

      // R9 disabled source never calls
      set_src(5'h00, 5'h00, 1'b1);
      @(negedge clk);
      int_pulse[0] = 1'b1;
      @(negedge clk);
      int_pulse = '0;
      repeat (3) @(negedge clk);
      check("R9 disabled flag set", ctl0_q, 8'h41);
      check("R9 disabled no call", call_req, 0);
      check("R11 no wake when disabled", wake, 0);

      // R10 stack full holds the request
      stack_full = 1'b1;
      set_src(5'h1F, 5'h04, 1'b1);
      begin
         int seen;
         seen = 0;
         for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (call_req) seen++;
         end
         check("R10 no call while stack full", seen, 0);
      end
      check("R10 flag kept", ctl0_q, 8'h4F);
      check("R11 wake while stack full", wake, 1);
      stack_full = 1'b0;
      @(negedge clk);
      check("R10 call after stack frees", call_req, 1);
      check("R10 vector", call_vec, 8'h0C);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule